// File: doc/BRIEF.md
# Sticky Interrupt Status Controller

This block gathers single-cycle event pulses from a three-phase metering datapath and keeps them in a 20-bit status register. Once a flag is set, it stays set until software clears it. A 20-bit mask register selects which flags may pull the active-low interrupt line. Software reads the status through a registered read port that has two addresses. One address returns the flags and leaves them unchanged. The other returns the flags and clears them in the same step.

Some flags are not driven by a direct pulse. They come from small detectors inside the block:
- Three half-full detectors watch one chosen bit of each per-phase energy accumulator.
- A phase-order checker watches the three rising zero-crossing pulses.

The reset flag is set by reset and clears itself one cycle after the internal reset is released.

Top module: `irq_status_ctrl`

## Requirements
- R1: A flag set to 1 by its event stays at 1 in later cycles until it is cleared at the clear address, even after the event input has returned to 0. The reset flag is the one exception (see R7).
- R2: `irq_n` is 0 exactly when some status bit and the same bit of the mask are both 1. It is 1 during reset and after reset.
- R3: A read strobe at address 0 loads `rd_data` with the status as it stood before that clock edge, and leaves the flags unchanged. A read at any address other than 0 or 1 returns 0 and has no effect on the flags.
- R4: A read strobe at address 1 loads `rd_data` with the status as it stood before that edge, and clears every flag at that same edge.
- R5: An event that arrives in the same cycle as a read at address 1 leaves its flag at 1 after that edge.
- R6: Flag positions are fixed as follows:
  - bit 0: active-energy half-full
  - bit 1: reactive-energy half-full
  - bit 2: apparent-energy half-full
  - bits 3, 4, 5: sag on phases A, B, C
  - bits 6, 7, 8: zero-crossing timeout on phases A, B, C
  - bits 9, 10, 11: rising zero crossing on phases A, B, C
  - bit 12: line-cycle accumulation end
  - bit 13: reset
  - bit 14: voltage peak
  - bit 15: current peak
  - bit 16: new waveform sample
  - bit 17: active power sign reversal
  - bit 18: reactive power sign reversal
  - bit 19: phase-sequence error
  In each three-bit event input, element 0 is phase A, element 1 is phase B and element 2 is phase C.
- R7: The reset flag (bit 13) is 1 after reset. It stays at 1 through the first clock edge after the internal reset is released, and is 0 from then on. All other flags are 0 after reset.
- R8: The active-energy flag and the reactive-energy flag each set when any of their three watched accumulator bits differs from its value in the previous cycle. A change in either direction counts. After reset, the previous value of every watched bit is taken as 0.
- R9: The apparent-energy flag sets only when one of its three watched bits goes from 0 to 1. A 1-to-0 change has no effect.
- R10: After a phase A zero crossing, the sequence-error flag sets if the next zero crossing on phase B or C comes from phase B. If it comes from phase C, the flag does not set. If phase B and phase C cross in the same cycle while armed, the flag sets. A new phase A crossing re-arms the check.
- R11: The mask register resets to 0. It loads `mask_wdata` at the clock edge where `mask_we` is 1, and `irq_n` reflects the new mask from that edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| mask_we | input | 1 | Mask write strobe |
| mask_wdata | input | 20 | New mask value |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 4 | Read address: 0 reads the status, 1 reads and clears it |
| rd_data | output | 20 | Registered read result |
| irq_n | output | 1 | Active-low interrupt request |
| act_b14 | input | 3 | Watched bit of each active-energy accumulator |
| react_b14 | input | 3 | Watched bit of each reactive-energy accumulator |
| app_b15 | input | 3 | Watched bit of each apparent-energy accumulator |
| sag_ev | input | 3 | Sag pulses, phases A to C |
| zxto_ev | input | 3 | Zero-crossing timeout pulses |
| zx_ev | input | 3 | Rising zero-crossing pulses |
| lcyc_ev | input | 1 | Line-cycle accumulation end pulse |
| pkv_ev | input | 1 | Voltage peak pulse |
| pki_ev | input | 1 | Current peak pulse |
| wfm_ev | input | 1 | New waveform sample pulse |
| revp_ev | input | 1 | Active power sign reversal pulse |
| revq_ev | input | 1 | Reactive power sign reversal pulse |

## Verification
Every event, whether it is a direct pulse or comes from a detector, lands in the status register at the same edge where it is sampled. A read therefore shows that event only when the read is strobed at a later edge. `rd_data` changes at the edge where the strobe is sampled, and it carries the status as it stood before that edge. `irq_n` follows the status and mask registers at that same edge, without further delay. The bench drives the inputs one time unit after the rising edge and updates its model for the coming edge. It samples both outputs one unit after that edge. For the reset flag, it counts the two synchronizer edges before the read that must still see bit 13 set.

// File: rtl/irqs_pkg.sv
package irqs_pkg;
  localparam int NFLAG   = 20;
  localparam int NPHASE  = 3;
  localparam int ADDR_W  = 4;
  localparam logic [ADDR_W-1:0] A_STAT     = 4'd0;
  localparam logic [ADDR_W-1:0] A_STAT_CLR = 4'd1;
  localparam int F_AEHALF = 0;
  localparam int F_REHALF = 1;
  localparam int F_SEHALF = 2;
  localparam int F_SAG0   = 3;
  localparam int F_ZXTO0  = 6;
  localparam int F_ZX0    = 9;
  localparam int F_LCYC   = 12;
  localparam int F_RST    = 13;
  localparam int F_PKV    = 14;
  localparam int F_PKI    = 15;
  localparam int F_WFM    = 16;
  localparam int F_REVP   = 17;
  localparam int F_REVQ   = 18;
  localparam int F_SEQ    = 19;
  localparam logic [NFLAG-1:0] RST_MASK = NFLAG'(1) << F_RST;
endpackage

// File: rtl/hf_detect.sv
module hf_detect #(
  parameter int NPH       = 3,
  parameter bit RISE_ONLY = 1'b0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NPH-1:0] bits_i,
  output logic           hit_o
);
  logic [NPH-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= bits_i;
  end

  generate
    if (RISE_ONLY) begin : g_rise
      assign hit_o = |(bits_i & ~prev_q);
    end else begin : g_any
      assign hit_o = |(bits_i ^ prev_q);
    end
  endgenerate
endmodule

// File: rtl/seq_check.sv
module seq_check (
  input  logic clk,
  input  logic rst_n,
  input  logic zx_a,
  input  logic zx_b,
  input  logic zx_c,
  output logic seq_err
);
  logic armed_q, armed_d;

  assign seq_err = armed_q & zx_b;

  always_comb begin
    armed_d = armed_q;
    if (zx_a)             armed_d = 1'b1;
    else if (zx_b | zx_c) armed_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= armed_d;
  end

  // R10
  disarm_after_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_err && !zx_a) |=> !armed_q);
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irqs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mask_we,
  input  logic [NFLAG-1:0]  mask_wdata,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [NFLAG-1:0]  rd_data,
  output logic              irq_n,
  input  logic [NPHASE-1:0] act_b14,
  input  logic [NPHASE-1:0] react_b14,
  input  logic [NPHASE-1:0] app_b15,
  input  logic [NPHASE-1:0] sag_ev,
  input  logic [NPHASE-1:0] zxto_ev,
  input  logic [NPHASE-1:0] zx_ev,
  input  logic              lcyc_ev,
  input  logic              pkv_ev,
  input  logic              pki_ev,
  input  logic              wfm_ev,
  input  logic              revp_ev,
  input  logic              revq_ev
);
  logic             sync1_q, srst_n;
  logic             hf_p, hf_q, hf_s, seq_hit;
  logic [NFLAG-1:0] ev_vec, status_q, status_d, mask_q, rd_q, rd_d;
  logic             rd_clr, rd_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      srst_n  <= 1'b0;
    end else begin
      sync1_q <= 1'b1;
      srst_n  <= sync1_q;
    end
  end

  hf_detect #(.NPH(NPHASE), .RISE_ONLY(1'b0)) u_hf_p (
    .clk(clk), .rst_n(srst_n), .bits_i(act_b14), .hit_o(hf_p));
  hf_detect #(.NPH(NPHASE), .RISE_ONLY(1'b0)) u_hf_q (
    .clk(clk), .rst_n(srst_n), .bits_i(react_b14), .hit_o(hf_q));
  hf_detect #(.NPH(NPHASE), .RISE_ONLY(1'b1)) u_hf_s (
    .clk(clk), .rst_n(srst_n), .bits_i(app_b15), .hit_o(hf_s));

  seq_check u_seq (
    .clk(clk), .rst_n(srst_n), .zx_a(zx_ev[0]), .zx_b(zx_ev[1]),
    .zx_c(zx_ev[2]), .seq_err(seq_hit));

  always_comb begin
    ev_vec = '0;
    ev_vec[F_AEHALF] = hf_p;
    ev_vec[F_REHALF] = hf_q;
    ev_vec[F_SEHALF] = hf_s;
    ev_vec[F_SAG0  +: NPHASE] = sag_ev;
    ev_vec[F_ZXTO0 +: NPHASE] = zxto_ev;
    ev_vec[F_ZX0   +: NPHASE] = zx_ev;
    ev_vec[F_LCYC] = lcyc_ev;
    ev_vec[F_PKV]  = pkv_ev;
    ev_vec[F_PKI]  = pki_ev;
    ev_vec[F_WFM]  = wfm_ev;
    ev_vec[F_REVP] = revp_ev;
    ev_vec[F_REVQ] = revq_ev;
    ev_vec[F_SEQ]  = seq_hit;
  end

  assign rd_clr = rd_en && (rd_addr == A_STAT_CLR);
  assign rd_ok  = (rd_addr == A_STAT) || (rd_addr == A_STAT_CLR);

  always_comb begin
    status_d = rd_clr ? '0 : (status_q & ~RST_MASK);
    status_d = status_d | ev_vec;
    rd_d     = rd_ok ? status_q : '0;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      status_q <= RST_MASK;
      mask_q   <= '0;
      rd_q     <= '0;
    end else begin
      status_q <= status_d;
      if (mask_we) mask_q <= mask_wdata;
      if (rd_en)   rd_q   <= rd_d;
    end
  end

  assign rd_data = rd_q;
  assign irq_n   = ~|(status_q & mask_q);

  // R1
  sticky_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !rd_clr |=> ((status_q & $past(status_q & ~RST_MASK)) == $past(status_q & ~RST_MASK)));
  // R4
  clear_on_read_chk: assert property (@(posedge clk) disable iff (!srst_n)
    rd_clr |=> ((status_q & ~$past(ev_vec)) == '0));
  // R5
  event_beats_clear_chk: assert property (@(posedge clk) disable iff (!srst_n)
    rd_clr |=> ((status_q & $past(ev_vec)) == $past(ev_vec)));
  // R7
  reset_flag_pulse_chk: assert property (@(posedge clk) disable iff (!srst_n)
    status_q[F_RST] |=> !status_q[F_RST]);
endmodule

// File: tb/irq_status_ctrl_tb.sv
`timescale 1ns/1ps
module irq_status_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n;
  logic mask_we;
  logic [19:0] mask_wdata;
  logic rd_en;
  logic [3:0] rd_addr;
  logic [19:0] rd_data;
  logic irq_n;
  logic [2:0] act_b14, react_b14, app_b15, sag_ev, zxto_ev, zx_ev;
  logic lcyc_ev, pkv_ev, pki_ev, wfm_ev, revp_ev, revq_ev;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [19:0] m_stat, m_mask, m_rd;
  logic [2:0]  m_pa, m_pq, m_ps;
  logic        m_arm;

  always #2.5 clk = ~clk;

  irq_status_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .mask_we(mask_we), .mask_wdata(mask_wdata),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .irq_n(irq_n),
    .act_b14(act_b14), .react_b14(react_b14), .app_b15(app_b15),
    .sag_ev(sag_ev), .zxto_ev(zxto_ev), .zx_ev(zx_ev), .lcyc_ev(lcyc_ev),
    .pkv_ev(pkv_ev), .pki_ev(pki_ev), .wfm_ev(wfm_ev), .revp_ev(revp_ev),
    .revq_ev(revq_ev));

  task automatic check(input bit ok, input string tag, input logic [19:0] act,
                       input logic [19:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%05h expected=%05h", tag, act, exp);
    end
  endtask

  function automatic logic [19:0] model_ev();
    logic [19:0] e;
    e = '0;
    e[0] = |(act_b14 ^ m_pa);
    e[1] = |(react_b14 ^ m_pq);
    e[2] = |(app_b15 & ~m_ps);
    e[5:3] = sag_ev;
    e[8:6] = zxto_ev;
    e[11:9] = zx_ev;
    e[12] = lcyc_ev;
    e[14] = pkv_ev;
    e[15] = pki_ev;
    e[16] = wfm_ev;
    e[17] = revp_ev;
    e[18] = revq_ev;
    e[19] = m_arm & zx_ev[1];
    return e;
  endfunction

  task automatic clear_pulses();
    sag_ev = '0; zxto_ev = '0; zx_ev = '0;
    lcyc_ev = 0; pkv_ev = 0; pki_ev = 0; wfm_ev = 0; revp_ev = 0; revq_ev = 0;
    rd_en = 0; rd_addr = '0; mask_we = 0; mask_wdata = '0;
  endtask

  // one clock: update model for the coming edge, then check outputs after it
  task automatic tick();
    logic [19:0] ev;
    logic clr;
    string rtag;
    ev  = model_ev();
    clr = rd_en && (rd_addr == 4'd1);
    rtag = (rd_addr == 4'd1) ? "R4 read data" : "R3 read data";
    if (rd_en) m_rd = (rd_addr <= 4'd1) ? m_stat : '0;
    m_stat = ((clr ? 20'h0 : m_stat) & ~20'h02000) | ev;
    if (mask_we) m_mask = mask_wdata;
    m_pa = act_b14; m_pq = react_b14; m_ps = app_b15;
    if (zx_ev[0]) m_arm = 1'b1;
    else if (zx_ev[1] | zx_ev[2]) m_arm = 1'b0;
    @(posedge clk);
    #1;
    check(rd_data === m_rd, rtag, rd_data, m_rd);
    check(irq_n === ~|(m_stat & m_mask), "R2 irq_n", {19'b0, irq_n},
          {19'b0, ~|(m_stat & m_mask)});
    clear_pulses();
  endtask

  task automatic rd(input logic [3:0] a);
    rd_en = 1; rd_addr = a;
    tick();
  endtask

  initial begin
    int unsigned seedv;
    seedv = $urandom(32'd2024);
    rst_n = 0;
    clear_pulses();
    act_b14 = '0; react_b14 = '0; app_b15 = '0;
    m_stat = 20'h02000; m_mask = '0; m_rd = '0;
    m_pa = '0; m_pq = '0; m_ps = '0; m_arm = 0;
    repeat (3) @(posedge clk);
    #1;
    check(irq_n === 1'b1, "R2 irq_n in reset", {19'b0, irq_n}, 20'h1);
    check(rd_data === 20'h0, "R3 rd_data in reset", rd_data, 20'h0);
    rst_n = 1;
    @(posedge clk); @(posedge clk); #1;
    // R7: first read after internal release still sees the reset flag
    rd(4'd0);
    check(rd_data === 20'h02000, "R7 reset flag set", rd_data, 20'h02000);
    rd(4'd0);
    check(rd_data === 20'h0, "R7 reset flag self-cleared", rd_data, 20'h0);

    // R6 / R1: sag on phase B -> bit 4, sticky over two plain reads
    sag_ev = 3'b010; tick();
    rd(4'd0);
    check(rd_data === 20'h00010, "R6 sag B at bit 4", rd_data, 20'h00010);
    rd(4'd0);
    check(rd_data === 20'h00010, "R1 R3 flag kept after plain read", rd_data, 20'h00010);

    // R11 / R2: mask that flag
    mask_we = 1; mask_wdata = 20'h00010; tick();
    check(irq_n === 1'b0, "R11 mask write asserts irq", {19'b0, irq_n}, 20'h0);

    // R5: clear with a simultaneous voltage-peak event
    pkv_ev = 1; rd(4'd1);
    check(rd_data === 20'h00010, "R4 clear read returns old", rd_data, 20'h00010);
    check(irq_n === 1'b1, "R2 irq released after clear", {19'b0, irq_n}, 20'h1);
    rd(4'd0);
    check(rd_data === 20'h04000, "R5 event during clear kept", rd_data, 20'h04000);
    rd(4'd1);

    // R9: apparent rise sets, fall does not
    app_b15 = 3'b100; tick(); rd(4'd1);
    check(rd_data === 20'h00004, "R9 apparent rise", rd_data, 20'h00004);
    app_b15 = 3'b000; tick(); rd(4'd1);
    check(rd_data === 20'h0, "R9 apparent fall ignored", rd_data, 20'h0);

    // R8: active rise and fall both count
    act_b14 = 3'b001; tick(); rd(4'd1);
    check(rd_data === 20'h00001, "R8 active change up", rd_data, 20'h00001);
    act_b14 = 3'b000; tick(); rd(4'd1);
    check(rd_data === 20'h00001, "R8 active change down", rd_data, 20'h00001);
    react_b14 = 3'b010; tick(); rd(4'd1);
    check(rd_data === 20'h00002, "R8 reactive change", rd_data, 20'h00002);

    // R10: A then B -> error; A then C then B -> none
    zx_ev = 3'b001; tick(); zx_ev = 3'b010; tick(); rd(4'd1);
    check(rd_data === 20'h80600, "R10 A then B flags error", rd_data, 20'h80600);
    zx_ev = 3'b001; tick(); zx_ev = 3'b100; tick(); zx_ev = 3'b010; tick(); rd(4'd1);
    check(rd_data === 20'h00E00, "R10 A C B no error", rd_data, 20'h00E00);

    // R3: unused address returns zero and leaves flags alone
    wfm_ev = 1; tick(); rd(4'd5);
    check(rd_data === 20'h0, "R3 other address reads zero", rd_data, 20'h0);
    rd(4'd0);
    check(rd_data === 20'h10000, "R3 other address no clear", rd_data, 20'h10000);

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      sag_ev  = (($urandom % 6) == 0) ? 3'($urandom) : 3'b0;
      zxto_ev = (($urandom % 8) == 0) ? 3'($urandom) : 3'b0;
      zx_ev   = (($urandom % 3) == 0) ? 3'($urandom) : 3'b0;
      lcyc_ev = ($urandom % 10) == 0;
      pkv_ev  = ($urandom % 10) == 0;
      pki_ev  = ($urandom % 10) == 0;
      wfm_ev  = ($urandom % 10) == 0;
      revp_ev = ($urandom % 12) == 0;
      revq_ev = ($urandom % 12) == 0;
      if (($urandom % 5) == 0) act_b14   = 3'($urandom);
      if (($urandom % 5) == 0) react_b14 = 3'($urandom);
      if (($urandom % 5) == 0) app_b15   = 3'($urandom);
      rd_en   = ($urandom % 3) == 0;
      rd_addr = 4'($urandom % 3);
      mask_we = ($urandom % 20) == 0;
      mask_wdata = 20'($urandom);
      tick();
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%05h expected=%05h", 20'h0, 20'h1);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule